// File: doc/BRIEF.md
# Watchdog and Clock Monitor Supervisor

This block keeps watch over a small controller core. It divides the core clock by a fixed ratio to make an instruction-cycle tick. Two supervisors run on that tick. The first is a watchdog that the core must service before a selectable number of ticks has passed. The second is a clock-frequency monitor. It counts ticks between rising edges of a reference strobe that comes from an independent slow timebase. When too few ticks fit between two reference edges, the core clock is judged too slow.

Both supervisors share one active-low error line, which is built like an open drain. The block outputs the value to drive, which is always low, and an enable. The pin floats whenever the enable is low. Out of reset, the watchdog runs with its longest window and the clock monitor is on. A service strobe captures the window code and the monitor enable, and it restarts the watchdog count.

A watchdog expiry is latched until reset. A clock fault is held through a fixed release delay after the clock has recovered, and that delay starts again if the clock fails during it.

Top module: `clkwd_supervisor`

## Requirements
- R1: One instruction tick occurs every `DIV` input clock cycles (default 10). All watchdog windows and monitor delays are counted in these ticks.
- R2: While `rstN` is low, `errOe` is 0 and neither supervisor can raise a fault, whatever `serviceStb` and `refTick` do.
- R3: After reset and before the first service strobe, the watchdog uses the largest window code (all ones) and the clock monitor is enabled, whatever the `winSel` and `monEn` inputs carry.
- R4: The watchdog window is 2^(`WIN_BASE_LOG2` + code) ticks, where code is the unsigned `winSel` value captured at the last service strobe. With the default base of 13 and a 2-bit code, the windows are 8K, 16K, 32K and 64K ticks.
- R5: A service strobe restarts the watchdog count, so a core that services more often than once per window never sees a watchdog fault.
- R6: When the window passes with no service, a watchdog fault is latched and `errOe` goes to 1. Later service strobes do not clear it; only reset does.
- R7: The monitor measures each interval between consecutive rising edges of `refTick`. The first interval starts at the first edge after reset. An interval shorter than `MON_THRESH` ticks raises a clock fault (`errOe` = 1) at the edge that ends it.
- R8: After a clock fault, the first interval of at least `MON_THRESH` ticks starts a release delay of `RELEASE_DLY` ticks (default 24). `errOe` stays 1 through that delay and then drops, unless a watchdog fault holds it.
- R9: A short interval that ends during the release delay puts the monitor back into the fault state. A fresh full delay is then needed after the next good interval.
- R10: A service strobe that captures `monEn` = 0 turns the monitor off and clears any clock fault. Short intervals then have no effect on `errOe`.
- R11: `errOut` is always 0, so the pin is only ever pulled low. Whether the pin is driven is decided by `errOe` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serviceStb | input | 1 | One-cycle watchdog service strobe; also captures winSel and monEn |
| winSel | input | SEL_W | Watchdog window code, captured on service |
| monEn | input | 1 | Clock monitor enable, captured on service |
| refTick | input | 1 | Reference strobe from an independent slow timebase (asynchronous) |
| errOut | output | 1 | Value to drive onto the error pin (constant 0) |
| errOe | output | 1 | Error pin output enable; 1 while any fault is active |

## Verification
The hardest state to reach is a clock that fails again during its own release delay. To get there, the stimulus first produces a run of short reference intervals. It then gives one long interval so that the delay begins, and 40 cycles into that delay it places a single short interval. After one more long interval, the bench checks that the error line is still held at a point where the first delay would already have let go. The watchdog windows are scaled down through `WIN_BASE_LOG2` so that every window code, including the all-ones code used from reset, expires within the run.

// File: rtl/clkwd_pkg.sv
`timescale 1ns/1ps
package clkwd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrWd;       // restart the watchdog count
    logic startDelay;  // zero the release-delay counter
    logic runDelay;    // let the release-delay counter advance on ticks
  } supCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic refEdge;        // synchronized rising edge of the reference strobe
    logic shortInterval;  // fewer than threshold ticks since the previous edge
    logic wdExpired;      // window limit reached on this tick
    logic delayDone;      // release delay fully counted
  } supStat_t;

  typedef enum logic [1:0] {
    MON_OK    = 2'd0,
    MON_FAULT = 2'd1,
    MON_HOLD  = 2'd2
  } monState_t;

endpackage

// File: rtl/clkwd_datapath.sv
`timescale 1ns/1ps
module clkwd_datapath
  import clkwd_pkg::*;
#(
  parameter int DIV           = 10,
  parameter int WIN_BASE_LOG2 = 13,
  parameter int SEL_W         = 2,
  parameter int MON_THRESH    = 8,
  parameter int RELEASE_DLY   = 24,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic [SEL_W-1:0] winSelQ,
  input  supCtl_t          ctl,
  output supStat_t         stat,
  output logic             tick
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WD_W  = WIN_BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int IV_W  = $clog2(MON_THRESH + 1);
  localparam int DL_W  = $clog2(RELEASE_DLY + 1);
  localparam logic [SEL_W-1:0] MAX_CODE = '1;
  localparam logic [WD_W-1:0]  ALL_ONES = '1;

  // ---------------- instruction tick divider ----------------
  logic [DIV_W-1:0] divCnt;
  logic             tickQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      tickQ  <= (divCnt == DIV_W'(DIV - 1));
      divCnt <= (divCnt == DIV_W'(DIV - 1)) ? '0 : divCnt + 1'b1;
    end
  end

  assign tick = tickQ;

  // ---------------- reference synchronizer and edge detect ----------------
  logic refSync;
  logic refPrev;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic refMeta;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) refMeta <= 1'b0;
        else       refMeta <= refTick;
      end
      assign refSync = refMeta;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] refPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) refPipe <= '0;
        else       refPipe <= {refPipe[SYNC_STAGES-2:0], refTick};
      end
      assign refSync = refPipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refPrev <= 1'b0;
    else       refPrev <= refSync;
  end

  assign stat.refEdge = refSync & ~refPrev;

  // ---------------- watchdog counter ----------------
  logic [WD_W-1:0] wdCnt;
  logic [WD_W-1:0] wdLimitM1;

  assign wdLimitM1      = ALL_ONES >> (MAX_CODE - winSelQ);
  assign stat.wdExpired = tickQ && (wdCnt == wdLimitM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wdCnt <= '0;
    else if (ctl.clrWd) wdCnt <= '0;
    else if (tickQ)    wdCnt <= wdCnt + 1'b1;
  end

  // ---------------- monitor interval counter (saturating) ----------------
  logic [IV_W-1:0] ivCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      ivCnt <= '0;
    else if (stat.refEdge)                          ivCnt <= '0;
    else if (tickQ && (ivCnt != IV_W'(MON_THRESH))) ivCnt <= ivCnt + 1'b1;
  end

  assign stat.shortInterval = (ivCnt < IV_W'(MON_THRESH));

  // ---------------- release delay counter ----------------
  logic [DL_W-1:0] dlyCnt;

  assign stat.delayDone = (dlyCnt == DL_W'(RELEASE_DLY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      dlyCnt <= '0;
    else if (ctl.startDelay)                        dlyCnt <= '0;
    else if (ctl.runDelay && tickQ && !stat.delayDone) dlyCnt <= dlyCnt + 1'b1;
  end

endmodule

// File: rtl/clkwd_control.sv
`timescale 1ns/1ps
module clkwd_control
  import clkwd_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serviceStb,
  input  logic [SEL_W-1:0] winSel,
  input  logic             monEn,
  input  supStat_t         stat,
  output supCtl_t          ctl,
  output logic [SEL_W-1:0] winSelQ,
  output logic             monEnQ,
  output logic             wdFault,
  output logic             monActive
);

  monState_t monState;
  monState_t monNext;
  logic      monArmed;
  logic      startDelay;

  // Configuration captured on service; armed at maximum out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winSelQ <= '1;
      monEnQ  <= 1'b1;
    end else if (serviceStb) begin
      winSelQ <= winSel;
      monEnQ  <= monEn;
    end
  end

  // Watchdog fault: sticky until reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wdFault <= 1'b0;
    else if (stat.wdExpired) wdFault <= 1'b1;
  end

  // First reference edge after reset opens the first measured interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             monArmed <= 1'b0;
    else if (stat.refEdge) monArmed <= 1'b1;
  end

  always_comb begin
    monNext    = monState;
    startDelay = 1'b0;
    if (!monEnQ) begin
      monNext = MON_OK;
    end else if (stat.refEdge && monArmed && stat.shortInterval) begin
      monNext = MON_FAULT;
    end else begin
      unique case (monState)
        MON_FAULT: begin
          if (stat.refEdge && monArmed) begin
            monNext    = MON_HOLD;
            startDelay = 1'b1;
          end
        end
        MON_HOLD: begin
          if (stat.delayDone) monNext = MON_OK;
        end
        default: monNext = monState;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) monState <= MON_OK;
    else       monState <= monNext;
  end

  assign ctl.clrWd      = serviceStb;
  assign ctl.startDelay = startDelay;
  assign ctl.runDelay   = (monState == MON_HOLD);
  assign monActive      = (monState != MON_OK);

endmodule

// File: rtl/clkwd_supervisor.sv
`timescale 1ns/1ps
module clkwd_supervisor
  import clkwd_pkg::*;
#(
  parameter int DIV           = 10,
  parameter int WIN_BASE_LOG2 = 13,
  parameter int SEL_W         = 2,
  parameter int MON_THRESH    = 8,
  parameter int RELEASE_DLY   = 24,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serviceStb,
  input  logic [SEL_W-1:0] winSel,
  input  logic             monEn,
  input  logic             refTick,
  output logic             errOut,
  output logic             errOe
);

  supCtl_t          ctl;
  supStat_t         stat;
  logic [SEL_W-1:0] winSelQ;
  logic             monEnQ;
  logic             wdFault;
  logic             monActive;
  logic             tick;

  clkwd_datapath #(
    .DIV(DIV), .WIN_BASE_LOG2(WIN_BASE_LOG2), .SEL_W(SEL_W),
    .MON_THRESH(MON_THRESH), .RELEASE_DLY(RELEASE_DLY), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .winSelQ(winSelQ),
    .ctl(ctl), .stat(stat), .tick(tick)
  );

  clkwd_control #(.SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .serviceStb(serviceStb), .winSel(winSel),
    .monEn(monEn), .stat(stat), .ctl(ctl), .winSelQ(winSelQ),
    .monEnQ(monEnQ), .wdFault(wdFault), .monActive(monActive)
  );

  assign errOut = 1'b0;
  assign errOe  = wdFault | monActive;

endmodule

// File: rtl/clkwd_supervisor_chk.sv
`timescale 1ns/1ps
module clkwd_supervisor_chk #(
  parameter int DIV = 10
) (
  input logic clk,
  input logic rstN,
  input logic errOe,
  input logic tick,
  input logic wdFault,
  input logic monActive,
  input logic monEnQ,
  input logic refEdge,
  input logic shortInterval
);

  int unsigned gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     gapCnt <= 0;
    else if (tick) gapCnt <= 1;
    else           gapCnt <= gapCnt + 1;
  end

  // R2: pin stays released while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r2_quiet_in_reset: assert (!errOe)
        else $error("R2: error pin enabled during reset");
    end
  end

  // R1: ticks are exactly DIV clocks apart
  a_r1_tick_period: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (gapCnt == DIV))
    else $error("R1: tick spacing wrong");

  // R6: watchdog fault persists until reset
  a_r6_wd_latched: assert property (@(posedge clk) disable iff (!rstN)
    wdFault |=> wdFault)
    else $error("R6: watchdog fault cleared without reset");

  // R9: a short interval while faulted or releasing keeps the clock fault
  a_r9_short_keeps_fault: assert property (@(posedge clk) disable iff (!rstN)
    (monActive && monEnQ && refEdge && shortInterval) |=> monActive)
    else $error("R9: short interval did not hold the clock fault");

endmodule

bind clkwd_supervisor clkwd_supervisor_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rstN(rstN), .errOe(errOe), .tick(tick),
  .wdFault(wdFault), .monActive(monActive), .monEnQ(monEnQ),
  .refEdge(stat.refEdge), .shortInterval(stat.shortInterval)
);

// File: tb/clkwd_supervisor_tb.sv
`timescale 1ns/1ps
module clkwd_supervisor_tb;

  localparam int DIV     = 10;
  localparam int BASE    = 4;   // windows 16, 32, 64, 128 ticks
  localparam int THRESH  = 8;
  localparam int RELDLY  = 24;

  logic       clk = 1'b0;
  logic       rstN;
  logic       serviceStb;
  logic [1:0] winSel;
  logic       monEn;
  logic       refTick;
  logic       errOut;
  logic       errOe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clkwd_supervisor #(
    .DIV(DIV), .WIN_BASE_LOG2(BASE), .SEL_W(2),
    .MON_THRESH(THRESH), .RELEASE_DLY(RELDLY), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .serviceStb(serviceStb), .winSel(winSel),
    .monEn(monEn), .refTick(refTick), .errOut(errOut), .errOe(errOe)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] sel, input logic en);
    rstN = 1'b0; serviceStb = 1'b0; refTick = 1'b0; winSel = sel; monEn = en;
    idle(20);
    rstN = 1'b1;
  endtask

  task automatic kick(input logic [1:0] sel, input logic en);
    winSel = sel; monEn = en; serviceStb = 1'b1;
    @(negedge clk);
    serviceStb = 1'b0;
  endtask

  task automatic refRise();
    refTick = 1'b1;
    idle(3);
    refTick = 1'b0;
  endtask

  task automatic measureFault(input int maxc, output int n);
    n = 0;
    while (!errOe && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  // R2, R11: quiet during reset even with stimulus
  task automatic t_reset();
    rstN = 1'b0; serviceStb = 1'b0; refTick = 1'b0; winSel = 2'b00; monEn = 1'b1;
    @(negedge clk);
    check(errOe == 1'b0, "R2 oe at reset", errOe, 0);
    for (int i = 0; i < 6; i++) begin refRise(); idle(20); end
    idle(1500);
    check(errOe == 1'b0, "R2 oe after long reset with short refs", errOe, 0);
    check(errOut == 1'b0, "R11 drive value", errOut, 0);
    rstN = 1'b1;
    idle(5);
    check(errOe == 1'b0, "R2 oe just after reset", errOe, 0);
  endtask

  // R3: maximum window before first service, despite winSel input 00
  task automatic t_startWindow();
    int n;
    doReset(2'b00, 1'b0);
    measureFault(2000, n);
    checkRange("R3 max window from reset", n, 1260, 1300);
  endtask

  // R6, R11: latched watchdog fault survives service, reset clears
  task automatic t_latch();
    for (int i = 0; i < 3; i++) begin kick(2'b00, 1'b1); idle(50); end
    check(errOe == 1'b1, "R6 fault latched after service", errOe, 1);
    check(errOut == 1'b0, "R11 drive value during fault", errOut, 0);
    doReset(2'b11, 1'b1);
    idle(2);
    check(errOe == 1'b0, "R6 reset clears fault", errOe, 0);
  endtask

  // R1, R4: window lengths for codes 0 and 1
  task automatic t_windows();
    int n;
    doReset(2'b11, 1'b1);
    idle(7);
    kick(2'b00, 1'b1);
    measureFault(2000, n);
    checkRange("R4 R1 window code 0 (16 ticks)", n, 145, 170);
    doReset(2'b11, 1'b1);
    idle(3);
    kick(2'b01, 1'b1);
    measureFault(2000, n);
    checkRange("R4 R1 window code 1 (32 ticks)", n, 305, 330);
  endtask

  // R5: periodic service prevents expiry
  task automatic t_service();
    doReset(2'b11, 1'b1);
    kick(2'b00, 1'b1);
    for (int i = 0; i < 15; i++) begin idle(100); kick(2'b00, 1'b1); end
    check(errOe == 1'b0, "R5 serviced watchdog quiet", errOe, 0);
  endtask

  // R7, R3: slow clock fault from reset, monitor on by default
  task automatic t_monFault();
    doReset(2'b11, 1'b0);
    refRise(); idle(20);
    check(errOe == 1'b0, "R7 first edge only opens interval", errOe, 0);
    idle(27);
    refRise(); idle(10);
    check(errOe == 1'b1, "R7 R3 short interval raises fault", errOe, 1);
  endtask

  // R8: release delay after a good interval
  task automatic t_release();
    refRise(); kick(2'b11, 1'b1); idle(196);   // edge A: still short
    refRise(); kick(2'b11, 1'b1); idle(146);   // edge B: good, delay starts
    check(errOe == 1'b1, "R8 held during release delay", errOe, 1);
    idle(180);
    check(errOe == 1'b0, "R8 released after delay", errOe, 0);
  endtask

  // R9: a short interval during the delay restarts it
  task automatic t_restart();
    doReset(2'b11, 1'b1);
    refRise(); idle(47);
    refRise(); idle(47);
    refRise(); kick(2'b11, 1'b1); idle(196);   // A
    refRise(); idle(37);                       // B good, delay begins
    refRise(); kick(2'b11, 1'b1); idle(196);   // C short, back to fault
    refRise(); kick(2'b11, 1'b1); idle(146);   // D good, delay restarts
    check(errOe == 1'b1, "R9 delay restarted after short interval", errOe, 1);
    idle(180);
    check(errOe == 1'b0, "R9 release after restarted delay", errOe, 0);
  endtask

  // R10: monitor disabled through service
  task automatic t_monOff();
    doReset(2'b11, 1'b1);
    kick(2'b11, 1'b0);
    for (int i = 0; i < 5; i++) begin refRise(); idle(47); end
    check(errOe == 1'b0, "R10 disabled monitor ignores short intervals", errOe, 0);
    kick(2'b11, 1'b1);
    for (int i = 0; i < 3; i++) begin refRise(); idle(47); end
    check(errOe == 1'b1, "R10 re-enabled monitor faults", errOe, 1);
    kick(2'b11, 1'b0);
    idle(3);
    check(errOe == 1'b0, "R10 disabling clears clock fault", errOe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finishRun();
  end

  initial begin
    t_reset();
    t_startWindow();
    t_latch();
    t_windows();
    t_service();
    t_monFault();
    t_release();
    t_restart();
    t_monOff();
    finishRun();
  end

endmodule